// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This block serves the move-to and move-from special-register instructions of a small 32-bit RISC core. A special-register address is sixteen bits wide: a five-bit group number sits above an eleven-bit register number. The address is therefore the group shifted left by 11 plus the register number. The unit holds a set of registers:

- the system and exception registers
- a bank of shadow general registers
- a 64-bit multiply-accumulate result
- the power-management register
- the mask and status registers of the interrupt controller

It also returns fixed configuration words that are set by parameters.

Writes take effect on the clock edge where `wr_en` is high. Reads are combinational. A read of an address the unit does not implement hands back the caller's previous destination value. Side effects leave the unit as registered strobes, one cycle after the write:

- a TLB flush when the MMU or privilege mode changes
- a fetch redirect when the next-PC register is written
- a sticky halt when a low-power mode is entered

Accesses to the tick timer's two registers are passed through to that timer.

Top module: `spr_access_unit`

## Requirements
- R1: After reset, every writable register reads zero. The version register (group 0, number 0) is the one exception and reads the `VERSION` parameter. Numbers 1, 2, 3 and 4 of group 0 read the unit-present, CPU, data-MMU and instruction-MMU configuration parameters. `tlb_flush_o`, `redirect_o`, `halt_o`, `sr_o` and `irq_o` are all 0.
- R2: These group-0 numbers are plain read/write registers: 0 (version), 11 (vector base), 18 (previous PC), 32 (exception PC), 48 (exception address) and 64 (exception status). A write is visible to a read from the cycle after the write edge.
- R3: Group 0 number 128 reads `CORE_INDEX` and number 129 reads `CORE_COUNT`. Writes to either address change nothing.
- R4: Group 0 numbers from 1024 up to 1024+32*`SHADOW_SETS`-1 are shadow registers. For an offset k from 1024, the set is k/32 and the register within the set is k%32. Numbers beyond that range are unmapped.
- R5: Group 5 number 1 reads and writes bits 31:0 of the 64-bit accumulator, and number 2 reads and writes bits 63:32. A write to one half leaves the other half unchanged.
- R6: Group 0 number 17 is the status register, driven on `sr_o`. A write that changes bit 0 (supervisor), bit 5 (data-MMU enable) or bit 6 (instruction-MMU enable) raises `tlb_flush_o` for exactly one cycle, in the cycle after the write. A write that changes none of those bits leaves `tlb_flush_o` low.
- R7: A write to group 8 number 0 stores the power-management value. If bit 4 (doze) or bit 5 (sleep) is set, `halt_o` rises in the next cycle and stays high until reset, and `halt_pc_o` equals `pc_in`+4 as sampled at the write.
- R8: A write to group 9 number 0 ORs the data into the interrupt mask. Mask bits are never cleared except by reset.
- R9: A write to group 9 number 2 clears every interrupt-status bit written as 1. Each cycle, the bits of `irq_pend_i` are ORed into the status register. `irq_o` is high when the status ANDed with the mask is nonzero.
- R10: A read of any other address returns `rd_prev`. This includes every address in groups 1 and 2, unlisted group-0 numbers and numbers above the shadow range. Writes to those addresses change no register.
- R11: A write to group 0 number 16 whose data differs from `pc_in` gives a one-cycle `redirect_o` pulse in the next cycle, with `redirect_pc_o` equal to the data. That pulse also tells the pipeline to drop its delay-slot state. A write equal to `pc_in` causes no redirect. A read of number 16 returns `pc_in`.
- R12: Group 10 numbers 0 and 1 belong to the tick timer. Reads there return `tmr_rd_data_i`, and `tmr_wr_o` follows a write to those numbers combinationally. Group 10 number 2 is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | Write address (group<<11 + number) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 16 | Read address |
| rd_prev | input | 32 | Previous destination value, returned for unmapped reads |
| rd_data | output | 32 | Read result |
| pc_in | input | 32 | Current PC from the pipeline |
| irq_pend_i | input | 32 | Interrupt lines that set status bits |
| tmr_rd_data_i | input | 32 | Read data from the tick timer |
| tmr_wr_o | output | 1 | Write strobe toward the tick timer |
| sr_o | output | 32 | Status register contents |
| irq_o | output | 1 | Unmasked interrupt pending |
| tlb_flush_o | output | 1 | Full TLB flush pulse |
| redirect_o | output | 1 | Fetch redirect and delay-slot clear pulse |
| redirect_pc_o | output | 32 | Redirect target |
| halt_o | output | 1 | Sticky halt |
| halt_pc_o | output | 32 | Resume PC after halt |

## Verification
The bench builds the unit with `SHADOW_SETS` = 2, `CORE_INDEX` = 3 and `CORE_COUNT` = 4, plus distinct configuration words. With two shadow sets the whole shadow range is 64 words. That is small enough to write every entry, and then to read all 2048 numbers of group 0 against a model held in the bench. The sweep covers the boundary at offset 64, where the shadow range ends and unmapped addresses begin. It also covers every unlisted number that must echo `rd_prev`. The side-effect checks cover both flushing and non-flushing status writes, both halting and non-halting power values, and next-PC writes that do and do not equal `pc_in`.

// File: rtl/spr_pkg.sv
package spr_pkg;

  localparam int SPR_AW      = 16;
  localparam int GRP_SHIFT   = 11;
  localparam int SHADOW_BASE = 1024;
  localparam int SET_REGS    = 32;

  // indices into the plain read/write bank
  localparam int PL_VER   = 0;
  localparam int PL_EVEC  = 1;
  localparam int PL_PREV  = 2;
  localparam int PL_EPC   = 3;
  localparam int PL_EADR  = 4;
  localparam int PL_ESTAT = 5;
  localparam int PLAIN_N  = 6;

  // status bits that select translation / privilege
  localparam int SR_SUPV = 0;
  localparam int SR_DMMU = 5;
  localparam int SR_IMMU = 6;
  // power-management bits that stop the core
  localparam int PM_DOZE  = 4;
  localparam int PM_SLEEP = 5;

  typedef enum logic [4:0] {
    K_NONE, K_UPR, K_CPUCFG, K_DMMUCFG, K_IMMUCFG, K_PLAIN, K_NPC, K_SR,
    K_COREID, K_NCORES, K_SHADOW, K_MACLO, K_MACHI, K_PMR, K_PICMR,
    K_PICSR, K_TIMER
  } spr_kind_e;

  function automatic logic [SPR_AW-1:0] spr_addr(input int grp, input int num);
    return SPR_AW'((grp << GRP_SHIFT) + num);
  endfunction

  function automatic logic [31:0] sr_mode_mask();
    return (32'd1 << SR_SUPV) | (32'd1 << SR_DMMU) | (32'd1 << SR_IMMU);
  endfunction

  function automatic logic [31:0] pm_stop_mask();
    return (32'd1 << PM_DOZE) | (32'd1 << PM_SLEEP);
  endfunction

  function automatic logic [31:0] or_in(input logic [31:0] cur, input logic [31:0] d);
    return cur | d;
  endfunction

  function automatic logic [31:0] ones_clear(input logic [31:0] cur, input logic [31:0] d);
    return cur & ~d;
  endfunction

endpackage

// File: rtl/spr_decode.sv
module spr_decode
  import spr_pkg::*;
#(
  parameter int SHADOW_SETS = 2,
  localparam int SH_N  = SHADOW_SETS * SET_REGS,
  localparam int IDX_W = $clog2(SH_N)
) (
  input  logic [SPR_AW-1:0] addr,
  output spr_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);

  logic [4:0]  grp;
  logic [31:0] num;

  assign grp = addr[SPR_AW-1:GRP_SHIFT];
  assign num = {21'd0, addr[GRP_SHIFT-1:0]};

  always_comb begin
    kind = K_NONE;
    idx  = '0;
    case (grp)
      5'd0: begin
        case (num)
          32'd0:   begin kind = K_PLAIN; idx = IDX_W'(PL_VER);   end
          32'd1:   kind = K_UPR;
          32'd2:   kind = K_CPUCFG;
          32'd3:   kind = K_DMMUCFG;
          32'd4:   kind = K_IMMUCFG;
          32'd11:  begin kind = K_PLAIN; idx = IDX_W'(PL_EVEC);  end
          32'd16:  kind = K_NPC;
          32'd17:  kind = K_SR;
          32'd18:  begin kind = K_PLAIN; idx = IDX_W'(PL_PREV);  end
          32'd32:  begin kind = K_PLAIN; idx = IDX_W'(PL_EPC);   end
          32'd48:  begin kind = K_PLAIN; idx = IDX_W'(PL_EADR);  end
          32'd64:  begin kind = K_PLAIN; idx = IDX_W'(PL_ESTAT); end
          32'd128: kind = K_COREID;
          32'd129: kind = K_NCORES;
          default: begin
            if (num >= 32'(SHADOW_BASE) && num < 32'(SHADOW_BASE + SH_N)) begin
              kind = K_SHADOW;
              idx  = IDX_W'(num - 32'(SHADOW_BASE));
            end
          end
        endcase
      end
      5'd5: begin
        if (num == 32'd1) kind = K_MACLO;
        else if (num == 32'd2) kind = K_MACHI;
      end
      5'd8:  if (num == 32'd0) kind = K_PMR;
      5'd9: begin
        if (num == 32'd0) kind = K_PICMR;
        else if (num == 32'd2) kind = K_PICSR;
      end
      5'd10: if (num < 32'd2) kind = K_TIMER;
      default: kind = K_NONE;
    endcase
  end

endmodule

// File: rtl/spr_plain_bank.sv
module spr_plain_bank #(
  parameter int XLEN = 32,
  parameter int N    = 6,
  parameter logic [N*XLEN-1:0] RST_VALS = '0,
  localparam int W = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [W-1:0]    widx,
  input  logic [XLEN-1:0] wdata,
  input  logic [W-1:0]    ridx,
  output logic [XLEN-1:0] rdata
);

  logic [XLEN-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[g] <= RST_VALS[g*XLEN +: XLEN];
      else if (we && widx == W'(g)) regs[g] <= wdata;
    end
  end

  assign rdata = regs[ridx];

endmodule

// File: rtl/spr_shadow_file.sv
module spr_shadow_file #(
  parameter int XLEN = 32,
  parameter int SETS = 2,
  localparam int SH_N  = SETS * 32,
  localparam int IDX_W = $clog2(SH_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [XLEN-1:0]  wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [XLEN-1:0]  rdata
);

  // flat index = set*32 + register, identical to the address offset
  logic [XLEN-1:0] mem [SH_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SH_N; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
  import spr_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int SHADOW_SETS = 2,
  parameter logic [XLEN-1:0] VERSION      = 32'h1200_0001,
  parameter logic [XLEN-1:0] UNIT_PRESENT = 32'h0000_0619,
  parameter logic [XLEN-1:0] CPU_CFG      = 32'h0000_0020,
  parameter logic [XLEN-1:0] DMMU_CFG     = 32'h0000_0018,
  parameter logic [XLEN-1:0] IMMU_CFG     = 32'h0000_0018,
  parameter logic [XLEN-1:0] CORE_INDEX   = 32'd0,
  parameter logic [XLEN-1:0] CORE_COUNT   = 32'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SPR_AW-1:0] wr_addr,
  input  logic [XLEN-1:0]   wr_data,
  input  logic [SPR_AW-1:0] rd_addr,
  input  logic [XLEN-1:0]   rd_prev,
  output logic [XLEN-1:0]   rd_data,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   irq_pend_i,
  input  logic [XLEN-1:0]   tmr_rd_data_i,
  output logic              tmr_wr_o,
  output logic [XLEN-1:0]   sr_o,
  output logic              irq_o,
  output logic              tlb_flush_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic              halt_o,
  output logic [XLEN-1:0]   halt_pc_o
);

  localparam int SH_N  = SHADOW_SETS * SET_REGS;
  localparam int IDX_W = $clog2(SH_N);
  localparam int PL_W  = $clog2(PLAIN_N);
  localparam logic [PLAIN_N*XLEN-1:0] PLAIN_RST = {{((PLAIN_N-1)*XLEN){1'b0}}, VERSION};

  spr_kind_e        wk, rk;
  logic [IDX_W-1:0] widx, ridx;
  logic [XLEN-1:0]  plain_rdata, sh_rdata;

  logic [XLEN-1:0]   sr_q, pmr_q, picmr_q, picsr_q;
  logic [2*XLEN-1:0] mac_q;

  // named internal events
  logic wr_hit_sr, mode_change, halt_req, npc_take, mac_lo_wr, unmapped_wr;

  spr_decode #(.SHADOW_SETS(SHADOW_SETS)) wr_dec_i (.addr(wr_addr), .kind(wk), .idx(widx));
  spr_decode #(.SHADOW_SETS(SHADOW_SETS)) rd_dec_i (.addr(rd_addr), .kind(rk), .idx(ridx));

  spr_plain_bank #(.XLEN(XLEN), .N(PLAIN_N), .RST_VALS(PLAIN_RST)) plain_i (
    .clk(clk), .rst_n(rst_n), .we(wr_en && wk == K_PLAIN),
    .widx(widx[PL_W-1:0]), .wdata(wr_data),
    .ridx(ridx[PL_W-1:0]), .rdata(plain_rdata)
  );

  spr_shadow_file #(.XLEN(XLEN), .SETS(SHADOW_SETS)) shadow_i (
    .clk(clk), .rst_n(rst_n), .we(wr_en && wk == K_SHADOW),
    .widx(widx), .wdata(wr_data), .ridx(ridx), .rdata(sh_rdata)
  );

  assign wr_hit_sr   = wr_en && wk == K_SR;
  assign mode_change = wr_hit_sr && (((sr_q ^ wr_data) & XLEN'(sr_mode_mask())) != '0);
  assign halt_req    = wr_en && wk == K_PMR && ((wr_data & XLEN'(pm_stop_mask())) != '0);
  assign npc_take    = wr_en && wk == K_NPC && wr_data != pc_in;
  assign mac_lo_wr   = wr_en && wk == K_MACLO;
  assign unmapped_wr = wr_en && wk == K_NONE;
  assign tmr_wr_o    = wr_en && wk == K_TIMER;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0; pmr_q <= '0; picmr_q <= '0; picsr_q <= '0; mac_q <= '0;
      tlb_flush_o <= 1'b0; redirect_o <= 1'b0; redirect_pc_o <= '0;
      halt_o <= 1'b0; halt_pc_o <= '0;
    end else begin
      if (wr_hit_sr) sr_q <= wr_data;
      if (wr_en && wk == K_PMR) pmr_q <= wr_data;
      if (wr_en && wk == K_PICMR) picmr_q <= or_in(picmr_q, wr_data);
      picsr_q <= (wr_en && wk == K_PICSR ? ones_clear(picsr_q, wr_data) : picsr_q) | irq_pend_i;
      if (mac_lo_wr) mac_q[XLEN-1:0] <= wr_data;
      if (wr_en && wk == K_MACHI) mac_q[2*XLEN-1:XLEN] <= wr_data;
      tlb_flush_o <= mode_change;
      redirect_o  <= npc_take;
      if (npc_take) redirect_pc_o <= wr_data;
      if (halt_req) begin
        halt_o    <= 1'b1;
        halt_pc_o <= pc_in + XLEN'(4);
      end
    end
  end

  assign sr_o  = sr_q;
  assign irq_o = (picsr_q & picmr_q) != '0;

  always_comb begin
    case (rk)
      K_UPR:     rd_data = UNIT_PRESENT;
      K_CPUCFG:  rd_data = CPU_CFG;
      K_DMMUCFG: rd_data = DMMU_CFG;
      K_IMMUCFG: rd_data = IMMU_CFG;
      K_PLAIN:   rd_data = plain_rdata;
      K_NPC:     rd_data = pc_in;
      K_SR:      rd_data = sr_q;
      K_COREID:  rd_data = CORE_INDEX;
      K_NCORES:  rd_data = CORE_COUNT;
      K_SHADOW:  rd_data = sh_rdata;
      K_MACLO:   rd_data = mac_q[XLEN-1:0];
      K_MACHI:   rd_data = mac_q[2*XLEN-1:XLEN];
      K_PMR:     rd_data = pmr_q;
      K_PICMR:   rd_data = picmr_q;
      K_PICSR:   rd_data = picsr_q;
      K_TIMER:   rd_data = tmr_rd_data_i;
      default:   rd_data = rd_prev;
    endcase
  end

  // R6
  flush_after_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush_o |-> $past(wr_hit_sr));

  // R7
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> halt_o);

  // R8
  mask_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((picmr_q & $past(picmr_q)) == $past(picmr_q)));

  // R9
  status_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((picsr_q & ~$past(picsr_q) & ~$past(irq_pend_i)) == '0));

  // R11
  redirect_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (redirect_pc_o != $past(pc_in)));

  // R5
  mac_half_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_lo_wr |=> $stable(mac_q[2*XLEN-1:XLEN]));

  // R10
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_wr |=> ($stable(sr_q) && $stable(pmr_q) && $stable(picmr_q) && $stable(mac_q)));

endmodule

// File: tb/spr_access_unit_tb.sv
`timescale 1ns/1ps
module spr_access_unit_tb_top;
  import spr_pkg::*;

  localparam logic [31:0] P_VER  = 32'h1200_0001;
  localparam logic [31:0] P_UPR  = 32'h0000_0619;
  localparam logic [31:0] P_CPU  = 32'h0000_0020;
  localparam logic [31:0] P_DMMU = 32'h0000_0118;
  localparam logic [31:0] P_IMMU = 32'h0000_0218;
  localparam int NSH = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_prev = '0, pc_in = '0, irq_pend_i = '0, tmr_rd_data_i = '0;
  logic [31:0] rd_data, sr_o, redirect_pc_o, halt_pc_o;
  logic tmr_wr_o, irq_o, tlb_flush_o, redirect_o, halt_o;

  always #4 clk = ~clk;

  spr_access_unit #(
    .XLEN(32), .SHADOW_SETS(2), .VERSION(P_VER), .UNIT_PRESENT(P_UPR),
    .CPU_CFG(P_CPU), .DMMU_CFG(P_DMMU), .IMMU_CFG(P_IMMU),
    .CORE_INDEX(32'd3), .CORE_COUNT(32'd4)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_prev(rd_prev), .rd_data(rd_data), .pc_in(pc_in),
    .irq_pend_i(irq_pend_i), .tmr_rd_data_i(tmr_rd_data_i), .tmr_wr_o(tmr_wr_o),
    .sr_o(sr_o), .irq_o(irq_o), .tlb_flush_o(tlb_flush_o), .redirect_o(redirect_o),
    .redirect_pc_o(redirect_pc_o), .halt_o(halt_o), .halt_pc_o(halt_pc_o)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model
  logic [31:0] m_ver, m_evec, m_prev, m_epc, m_eadr, m_estat, m_sr, m_pmr, m_mask, m_stat;
  logic [63:0] m_mac;
  logic [31:0] m_sh [NSH];

  function automatic logic [15:0] A(input int g, input int n);
    return 16'(g * 2048 + n);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [15:0] a, input logic [31:0] prev);
    int g, n;
    g = int'(a) / 2048;
    n = int'(a) % 2048;
    if (g == 0) begin
      if (n >= 1024 && n < 1024 + NSH) return m_sh[n - 1024];
      case (n)
        0: return m_ver;   1: return P_UPR;  2: return P_CPU;  3: return P_DMMU;
        4: return P_IMMU;  11: return m_evec; 16: return pc_in; 17: return m_sr;
        18: return m_prev; 32: return m_epc; 48: return m_eadr; 64: return m_estat;
        128: return 32'd3; 129: return 32'd4;
        default: return prev;
      endcase
    end
    if (g == 5 && n == 1) return m_mac[31:0];
    if (g == 5 && n == 2) return m_mac[63:32];
    if (g == 8 && n == 0) return m_pmr;
    if (g == 9 && n == 0) return m_mask;
    if (g == 9 && n == 2) return m_stat;
    if (g == 10 && n < 2) return tmr_rd_data_i;
    return prev;
  endfunction

  function automatic string tag_of(input logic [15:0] a);
    int n;
    n = int'(a) % 2048;
    if (int'(a) >= 2048) return "R10";
    if (n >= 1 && n <= 4) return "R1";
    if (n == 128 || n == 129) return "R3";
    if (n >= 1024 && n < 1024 + NSH) return "R4";
    if (n == 0 || n == 11 || n == 18 || n == 32 || n == 48 || n == 64) return "R2";
    if (n == 16) return "R11";
    if (n == 17) return "R6";
    return "R10";
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [31:0] d);
    int g, n;
    g = int'(a) / 2048;
    n = int'(a) % 2048;
    if (g == 0) begin
      if (n >= 1024 && n < 1024 + NSH) m_sh[n - 1024] = d;
      case (n)
        0: m_ver = d; 11: m_evec = d; 17: m_sr = d; 18: m_prev = d;
        32: m_epc = d; 48: m_eadr = d; 64: m_estat = d;
        default: ;
      endcase
    end
    if (g == 5 && n == 1) m_mac[31:0] = d;
    if (g == 5 && n == 2) m_mac[63:32] = d;
    if (g == 8 && n == 0) m_pmr = d;
    if (g == 9 && n == 0) m_mask = m_mask | d;
    if (g == 9 && n == 2) m_stat = m_stat & ~d;
  endtask

  // returns at the falling edge after the capturing rising edge
  task automatic spr_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    #1;
  endtask

  task automatic spr_read(input logic [15:0] a, input logic [31:0] prev, input string req);
    @(negedge clk);
    rd_addr = a; rd_prev = prev;
    #1;
    chk(req, rd_data, model_read(a, prev));
  endtask

  task automatic sweep_g0(input logic [31:0] seed);
    for (int n = 0; n < 2048; n++) begin
      logic [15:0] a;
      a = A(0, n);
      rd_addr = a; rd_prev = seed ^ 32'(n);
      #1;
      chk(tag_of(a), rd_data, model_read(a, seed ^ 32'(n)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_ver = P_VER; m_evec = 0; m_prev = 0; m_epc = 0; m_eadr = 0; m_estat = 0;
    m_sr = 0; m_pmr = 0; m_mask = 0; m_stat = 0; m_mac = 0;
    for (int i = 0; i < NSH; i++) m_sh[i] = 0;
    pc_in = 32'h100; tmr_rd_data_i = 32'h0000_BEEF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R1 reset state of outputs
    chk("R1", {27'd0, tlb_flush_o, redirect_o, halt_o, irq_o, tmr_wr_o}, 32'd0);
    chk("R1", sr_o, 32'd0);
    sweep_g0(32'hA5A5_0000);

    // R2 plain registers, R4 every shadow entry, R3 read-only words
    spr_write(A(0, 0), 32'h0BAD_0001);
    spr_write(A(0, 11), 32'h0000_2000);
    spr_write(A(0, 18), 32'h1111_2222);
    spr_write(A(0, 32), 32'h3333_4444);
    spr_write(A(0, 48), 32'h5555_6666);
    spr_write(A(0, 64), 32'h7777_8888);
    for (int i = 0; i < NSH; i++) spr_write(A(0, 1024 + i), 32'hC0DE_0000 + 32'(i * 3));
    spr_write(A(0, 1024 + NSH), 32'hDEAD_BEEF);  // R4 beyond range, ignored
    spr_write(A(0, 128), 32'h99);                // R3 ignored
    spr_write(A(0, 129), 32'h98);                // R3 ignored
    spr_write(A(0, 5), 32'h1234);                // R10 unlisted, ignored
    spr_write(A(1, 512), 32'hFFFF_FFFF);         // R10 group 1
    spr_write(A(2, 640), 32'hFFFF_FFFF);         // R10 group 2
    @(negedge clk);
    sweep_g0(32'h5A5A_0000);
    spr_read(A(1, 512), 32'h0000_1234, "R10");
    spr_read(A(2, 640), 32'h0000_4321, "R10");
    spr_read(A(0, 1024 + 33), 32'h0, "R4");  // set 1, register 1

    // R5 accumulator halves
    spr_write(A(5, 1), 32'hAAAA_0001);
    spr_write(A(5, 2), 32'hBBBB_0002);
    spr_write(A(5, 1), 32'hCCCC_0003);
    spr_read(A(5, 1), 32'h0, "R5");
    spr_read(A(5, 2), 32'h0, "R5");
    chk("R5", m_mac[63:32], 32'hBBBB_0002);

    // R6 mode-changing and non-changing status writes
    spr_write(A(0, 17), 32'h0000_0020);
    chk("R6", {31'd0, tlb_flush_o}, 32'd1);
    @(negedge clk); #1;
    chk("R6", {31'd0, tlb_flush_o}, 32'd0);
    spr_write(A(0, 17), 32'h0000_0028);
    chk("R6", {31'd0, tlb_flush_o}, 32'd0);
    chk("R6", sr_o, 32'h0000_0028);
    spr_write(A(0, 17), 32'h0000_0029);
    chk("R6", {31'd0, tlb_flush_o}, 32'd1);
    spr_write(A(0, 17), 32'h0000_0069);
    chk("R6", {31'd0, tlb_flush_o}, 32'd1);
    spr_read(A(0, 17), 32'h0, "R6");

    // R8 mask OR, R9 status set/clear and irq_o
    spr_write(A(9, 0), 32'h0000_000F);
    spr_write(A(9, 0), 32'h0000_00F0);
    spr_read(A(9, 0), 32'h0, "R8");
    chk("R8", m_mask, 32'h0000_00FF);
    @(negedge clk); irq_pend_i = 32'h0000_0033;
    @(negedge clk); irq_pend_i = 32'h0; m_stat = m_stat | 32'h33;
    #1;
    chk("R9", {31'd0, irq_o}, 32'd1);
    spr_read(A(9, 2), 32'h0, "R9");
    spr_write(A(9, 2), 32'h0000_0011);
    spr_read(A(9, 2), 32'h0, "R9");
    chk("R9", m_stat, 32'h0000_0022);
    spr_write(A(9, 2), 32'h0000_0022);
    chk("R9", {31'd0, irq_o}, 32'd0);

    // R11 next-PC writes
    pc_in = 32'h200;
    spr_write(A(0, 16), 32'h200);
    chk("R11", {31'd0, redirect_o}, 32'd0);
    spr_write(A(0, 16), 32'h300);
    chk("R11", {31'd0, redirect_o}, 32'd1);
    chk("R11", redirect_pc_o, 32'h300);
    @(negedge clk); #1;
    chk("R11", {31'd0, redirect_o}, 32'd0);
    spr_read(A(0, 16), 32'h0, "R11");

    // R12 timer passthrough
    spr_read(A(10, 0), 32'h77, "R12");
    spr_read(A(10, 1), 32'h77, "R12");
    spr_read(A(10, 2), 32'h77, "R12");
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A(10, 1); wr_data = 32'h5; #1;
    chk("R12", {31'd0, tmr_wr_o}, 32'd1);
    wr_addr = A(10, 2); #1;
    chk("R12", {31'd0, tmr_wr_o}, 32'd0);
    @(negedge clk); wr_en = 1'b0;

    // R7 power management
    spr_write(A(8, 0), 32'h0000_0001);
    chk("R7", {31'd0, halt_o}, 32'd0);
    spr_read(A(8, 0), 32'h0, "R7");
    pc_in = 32'h400;
    spr_write(A(8, 0), 32'h0000_0020);
    chk("R7", {31'd0, halt_o}, 32'd1);
    chk("R7", halt_pc_o, 32'h404);
    repeat (3) @(negedge clk); #1;
    chk("R7", {31'd0, halt_o}, 32'd1);

    @(negedge clk);
    sweep_g0(32'h0F0F_0000);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule